// File: doc/BRIEF.md
# Latency-Matched Sync Delay Line with Freeze

This block holds a small bundle of video synchronization bits for a fixed number of clock cycles. The number of cycles equals the constant pipeline latency of a companion pixel datapath, so horizontal and vertical sync leave the block in step with the pixel words they belong to. The sync bits are active low, so every stage of the line rests at logic high while reset is held. Input capture begins only on the second rising clock edge after reset is released.

A freeze control stops the line. While the control is high, the drive-enable flag is low. This flag stands in for a tri-state output, because tri-state pins are not used inside the block. Shifting stops from the second rising edge after the control rises, and the line keeps its contents. When the control falls, shifting resumes after the same two-edge delay and continues from the held contents. No sample is lost and none is repeated.

Top module: `sync_delay_line`

## Requirements
- R1: The line has 8 stages of 2 bits each. While it is running, a value presented on `sync_i` in cycle c appears on `sync_o` in cycle c+8, with bit positions unchanged.
- R2: While `rst_ni` is low, every stage is set to all ones at once, without waiting for a clock edge, so `sync_o` reads 2'b11.
- R3: Values on `sync_i` while `rst_ni` is low never reach `sync_o`.
- R4: After `rst_ni` rises, the first rising clock edge captures nothing. The first capture is on the second rising edge, and `sync_o` stays 2'b11 until that capture has travelled through all 8 stages.
- R5: `oe_o` is low in exactly the cycles in which `frz_i` is high, with no clock delay.
- R6: Shifting stops from the second rising edge after `frz_i` rises. `sync_o` then holds its value, and `sync_i` is ignored for as long as shifting is stopped.
- R7: Shifting resumes on the second rising edge after `frz_i` falls. The held samples continue in order, with no sample lost and none repeated.
- R8: A low `rst_ni` takes priority over a high `frz_i` and forces all stages to ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; sets all stages to ones |
| frz_i | input | 1 | Freeze and drive-disable control, active high |
| sync_i | input | 2 | Sync bits entering the line |
| sync_o | output | 2 | Sync bits delayed by 8 cycles |
| oe_o | output | 1 | Drive enable, low while `frz_i` is high |

## Verification
The freeze and the reset-release arming can overlap. If `frz_i` is already high when reset is released, or is raised within the first two edges after release, it meets the arming edge. The bench provokes this by asserting reset in the middle of a freeze and releasing it while `frz_i` is still high. Because the line stays all ones until both arming and the freeze delay allow a shift, the scoreboard queue must see its first push on exactly the right edge. The bench judges the result by comparing `sync_o` with that queue every cycle.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int unsigned SDL_DEPTH_DEF = 8;
  localparam int unsigned SDL_WIDTH_DEF = 2;
endpackage

// File: rtl/sdl_arm.sv
// Capture arm: the first edge after reset release only sets this flag.
module sdl_arm (
  input  logic clk_i,
  input  logic rst_ni,
  output logic arm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_o <= 1'b0;
    else         arm_o <= 1'b1;
  end

  a_r4_arm_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_o |=> arm_o);
endmodule

// File: rtl/sdl_freeze.sv
// One register stage on the freeze control; its output gates shifting.
module sdl_freeze (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frz_i,
  output logic frz_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frz_q_o <= 1'b0;
    else         frz_q_o <= frz_i;
  end

  a_r6_freeze_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_i |=> frz_q_o);
  a_r7_release_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frz_i |=> !frz_q_o);
endmodule

// File: rtl/sdl_shift.sv
module sdl_shift #(
  parameter int unsigned DEPTH = sdl_pkg::SDL_DEPTH_DEF,
  parameter int unsigned WIDTH = sdl_pkg::SDL_WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [WIDTH-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    logic [WIDTH-1:0] nxt;
    if (i == 0) begin : g_head
      assign nxt = d_i;
    end else begin : g_body
      assign nxt = stg_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   stg_q[i] <= '1;
      else if (en_i) stg_q[i] <= nxt;
    end
  end

  assign q_o = stg_q[LAST];

  if (DEPTH > 1) begin : g_chk
    a_r1_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |=> stg_q[LAST] == $past(stg_q[LAST-1]));
  end
  a_r6_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(stg_q[0]));
endmodule

// File: rtl/sync_delay_line.sv
module sync_delay_line #(
  parameter int unsigned DEPTH = sdl_pkg::SDL_DEPTH_DEF,
  parameter int unsigned WIDTH = sdl_pkg::SDL_WIDTH_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frz_i,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] sync_o,
  output logic             oe_o
);
  logic arm_q;
  logic frz_q;
  logic shift_en;

  sdl_arm u_arm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_o (arm_q)
  );

  sdl_freeze u_frz (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .frz_i  (frz_i),
    .frz_q_o(frz_q)
  );

  assign shift_en = arm_q & ~frz_q;

  sdl_shift #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (shift_en),
    .d_i   (sync_i),
    .q_o   (sync_o)
  );

  assign oe_o = ~frz_i;

  a_r4_high_until_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_q |-> sync_o == '1);
  a_r6_output_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_q |=> $stable(sync_o));
  a_r2_reset_value: assert property (@(negedge clk_i)
    !rst_ni |-> sync_o == '1);
endmodule

// File: tb/sim_sync_delay_line.sv
`timescale 1ns/1ps
module sim_sync_delay_line;
  localparam int DEPTH = 8;
  localparam int WIDTH = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frz = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic             oe;

  int checks = 0;
  int errors = 0;
  string tag = "R2";
  logic done = 1'b0;

  always #10 clk = ~clk;

  sync_delay_line #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk_i (clk),
    .rst_ni(rst_n),
    .frz_i (frz),
    .sync_i(din),
    .sync_o(dout),
    .oe_o  (oe)
  );

  // reference: queue front is the output stage
  logic [WIDTH-1:0] ref_q [$];
  logic             m_arm = 1'b0;
  logic             m_frz = 1'b0;

  task automatic ref_reset();
    ref_q.delete();
    for (int i = 0; i < DEPTH; i++) ref_q.push_back('1);
    m_arm = 1'b0;
    m_frz = 1'b0;
  endtask

  initial ref_reset();

  // driver side: pushes the expected item whenever the line is due to shift
  always @(posedge clk) begin
    if (!rst_n) begin
      ref_reset();
    end else begin
      if (m_arm && !m_frz) begin
        void'(ref_q.pop_front());
        ref_q.push_back(din);
      end
      m_arm = 1'b1;
      m_frz = frz;
    end
  end

  task automatic chk(input string t, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", t, $time, act, exp);
    end
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) chk({tag, "/R2"}, dout, '1);
      else        chk(tag, dout, ref_q[0]);
      checks++;
      if (oe !== ~frz) begin
        errors++;
        $display("FAIL R5 at %0t: actual oe %b expected %b", $time, oe, ~frz);
      end
    end
  end

  task automatic step(input logic r, input logic f, input logic [WIDTH-1:0] d);
    @(negedge clk);
    #1;
    rst_n = r;
    frz = f;
    din = d;
  endtask

  int n = 0;
  function automatic logic [WIDTH-1:0] pat();
    n++;
    return WIDTH'((n * 7 + n / 3) % (1 << WIDTH));
  endfunction

  task automatic run(input int cyc);
    for (int i = 0; i < cyc; i++) step(1'b1, 1'b0, pat());
  endtask

  task automatic freeze_window(input int len);
    tag = "R6";
    for (int i = 0; i < len; i++) step(1'b1, 1'b1, pat());
    tag = "R7";
    run(DEPTH + 3);
  endtask

  initial begin
    // R3: busy input during reset must not reach the output
    tag = "R3";
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 2'(i));
    // R4: release with distinct data; first edge after release captures nothing
    tag = "R4";
    step(1'b1, 1'b0, 2'b00);
    step(1'b1, 1'b0, 2'b01);
    step(1'b1, 1'b0, 2'b10);
    run(DEPTH + 2);
    tag = "R1";
    run(24);
    // R6/R7: freeze windows of varying length
    freeze_window(1);
    freeze_window(2);
    freeze_window(5);
    freeze_window(12);
    // R8: reset during a freeze, released while still frozen
    tag = "R8";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, pat());
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, pat());
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, pat());
    tag = "R7";
    run(DEPTH + 4);
    // R2: reset asserted on a running line
    tag = "R2";
    run(5);
    step(1'b0, 1'b0, 2'b00);
    @(posedge clk);
    #3;
    chk("R2 async", dout, '1);
    step(1'b1, 1'b0, 2'b00);
    tag = "R1";
    run(DEPTH + 6);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule